// File: doc/BRIEF.md
# Buffered Triangle-Wave PWM Timer Channel

This block is one timer channel that drives two PWM pins from a shared counter. The counter runs in one of three shapes: a rising sawtooth, a falling sawtooth, or a triangle that climbs to a programmed limit and then descends back to zero. Each pin has its own compare value. The pin is asserted while the counter is on the active side of that value, so the triangle shape gives centre-aligned pulses. A one-cycle flag marks each top and each bottom of the count.

Software never writes the live compare values. It writes buffer registers: a near and a far buffer per compare, four buffers in all. The live value is reloaded from them only at a counter turning point (a crest, a trough, or both) or when the channel starts. With crest-and-trough reloading, the near buffer sets the rising half of a triangle pulse and the far buffer sets the falling half, so left and right edges can be placed independently. With buffering off, the near buffer acts directly as the compare value.

A complementary option makes the second pin the inverse of the first. Programmable dead time delays every rising pin edge, so the two pins are never high together. When the channel is stopped, both pins rest at programmable idle levels.

Top module: `pwm_tri_timer`

## Requirements
- R1: After reset, both pins are low (idle levels reset to 0), the counter is 0, and both flags are low.
- R2: Mode 0 (rising sawtooth) counts 0..P and returns to 0 after P, where P is the limit at address 0. The top flag pulses once every P+1 clocks. A pin is high for C clocks per frame, where C is its live compare value.
- R3: Mode 1 (falling sawtooth) counts down and reloads P after 0. The bottom flag pulses once every P+1 clocks. A pin is high for C clocks per frame.
- R4: Modes 2 and 3 (triangle) count up to P and then down to 0. Each flag pulses once every 2P clocks. A pin rises after an upward pass of C and falls after a downward pass of C, so it is high for 2(P−C) clocks.
- R5: Control bits [3:2] select the reload point in triangle mode: 0 or 1 reloads from the near buffer at the trough, 2 reloads from the near buffer at the crest, and 3 reloads from the near buffer at the trough and from the far buffer at the crest. With Cn (near) and Cf (far) in setting 3, the pulse width is (P−Cn)+(P−Cf). A start also loads the near buffer.
- R6: With buffering on (control bit 4 = 1), the live compare value changes only at a selected reload point or at a start. A buffer write that lands on the same clock as a reload is used at the following reload.
- R7: With buffering off (control bit 4 = 0), the live compare value follows the near buffer one clock after the write.
- R8: Control bit 5 makes pin B the inverse of pin A's waveform. Dead time D (control bits [31:8]) delays each rising pin edge by D clocks, giving pin A 2(P−C)−D, pin B 2C−D, and a gap of D clocks between A falling and B rising. The two pins are never high together.
- R9: A waveform pulse of D clocks or fewer never appears on its pin.
- R10: A stop sets pin A to control bit 6 and pin B to control bit 7 from the next clock, and the counter holds its value while stopped.
- R11: A clear sets the counter to 0 with an upward direction on the next clock, whether the channel is running or stopped.
- R12: Register addresses: 0 limit, 1 near A, 2 far A, 3 near B, 4 far B, 5 control. Control bits [1:0] hold the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| start | input | 1 | Start counting (one-clock pulse) |
| stop | input | 1 | Stop counting; has priority over start |
| clr | input | 1 | Zero the counter and set the direction to up |
| pin_a | output | 1 | PWM output A |
| pin_b | output | 1 | PWM output B |
| irq_ovf | output | 1 | One-clock flag at the top of the count |
| irq_unf | output | 1 | One-clock flag at the bottom of the count |
| cnt_o | output | CW | Counter value |
| cnt_up_o | output | 1 | Counter direction, 1 = up |

## Verification
The counter value and direction appear one clock after a control pulse. A flag appears one clock after the counter sits at its limit. A pin edge appears two clocks after the counter value that causes it: one clock for the waveform register and one for the dead-time register. Idle levels appear in the same clock that the stop takes effect. Because every latency is fixed, the bench measures pulse widths, flag intervals and dead-time gaps as counts of falling-edge samples, so the latencies cancel. Where a result is due at a known edge (reset state, stop, clear, a write timed onto a trough), the bench samples at the falling edge that follows exactly that rising edge.

// File: rtl/pwm_tri_pkg.sv
`timescale 1ns/1ps
package pwm_tri_pkg;

    typedef enum logic [1:0] {
        CNT_UP   = 2'd0,
        CNT_DN   = 2'd1,
        CNT_TRI  = 2'd2,
        CNT_TRI2 = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        XF_TROUGH0 = 2'd0,
        XF_TROUGH  = 2'd1,
        XF_CREST   = 2'd2,
        XF_BOTH    = 2'd3
    } xfer_e;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] AD_LIMIT = 3'd0;
    localparam logic [ADDR_W-1:0] AD_CTRL  = 3'd5;

    // 8 low control bits, msb first
    typedef struct packed {
        logic      idle_b;
        logic      idle_a;
        logic      comp;
        logic      buf_en;
        xfer_e     xfer;
        cnt_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/pwm_cnt.sv
`timescale 1ns/1ps
module pwm_cnt
    import pwm_tri_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          clr,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] period,
    output logic          run,
    output logic [CW-1:0] cnt,
    output logic          up,
    output logic          top_ev,
    output logic          bot_ev
);

    typedef struct packed {
        logic          run;
        logic          up;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        top_ev = s_q.run && (s_q.cnt >= period)
                 && ((mode == CNT_UP) || (mode[1] && s_q.up));
        bot_ev = s_q.run && (s_q.cnt == '0)
                 && ((mode == CNT_DN) || (mode[1] && !s_q.up));

        s_d = s_q;
        if (stop)       s_d.run = 1'b0;
        else if (start) s_d.run = 1'b1;

        if (clr) begin
            s_d.cnt = '0;
            s_d.up  = 1'b1;
        end else if (s_q.run) begin
            unique case (mode)
                CNT_UP: begin
                    s_d.up  = 1'b1;
                    s_d.cnt = top_ev ? '0 : s_q.cnt + CW'(1);
                end
                CNT_DN: begin
                    s_d.up  = 1'b0;
                    s_d.cnt = bot_ev ? period : s_q.cnt - CW'(1);
                end
                default: begin
                    if (s_q.up) begin
                        if (s_q.cnt >= period) begin
                            s_d.up  = 1'b0;
                            s_d.cnt = s_q.cnt - CW'(1);
                        end else begin
                            s_d.cnt = s_q.cnt + CW'(1);
                        end
                    end else begin
                        if (s_q.cnt == '0) begin
                            s_d.up  = 1'b1;
                            s_d.cnt = s_q.cnt + CW'(1);
                        end else begin
                            s_d.cnt = s_q.cnt - CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{run: 1'b0, up: 1'b1, cnt: '0};
        else        s_q <= s_d;
    end

    assign run = s_q.run;
    assign cnt = s_q.cnt;
    assign up  = s_q.up;

    // R2
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !clr && mode == CNT_UP && s_q.cnt == period) |=> (s_q.cnt == '0));

    // R3
    reload_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !clr && mode == CNT_DN && s_q.cnt == '0) |=> (s_q.cnt == $past(period)));

    // R4
    crest_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !clr && mode[1] && s_q.up && s_q.cnt == period && period != '0)
        |=> (!s_q.up && s_q.cnt == $past(period) - CW'(1)));

    // R11
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0 && s_q.up));

    // R10
    hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !clr) |=> $stable(s_q.cnt));

endmodule

// File: rtl/pwm_cmp.sv
`timescale 1ns/1ps
module pwm_cmp
    import pwm_tri_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_near,
    input  logic          wr_far,
    input  logic [CW-1:0] wdata,
    input  logic          buf_en,
    input  xfer_e         xfer,
    input  logic          tri_mode,
    input  logic          load,
    input  logic          top_ev,
    input  logic          bot_ev,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          up,
    output logic          wave
);

    typedef struct packed {
        logic [CW-1:0] near;
        logic [CW-1:0] far;
        logic [CW-1:0] act;
        logic          wave;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_near) s_d.near = wdata;
        if (wr_far)  s_d.far  = wdata;

        // live compare reload, reads buffers before this clock's write
        if (!buf_en || load) begin
            s_d.act = s_q.near;
        end else if (tri_mode) begin
            if (bot_ev && xfer != XF_CREST) s_d.act = s_q.near;
            if (top_ev && xfer == XF_CREST) s_d.act = s_q.near;
            if (top_ev && xfer == XF_BOTH)  s_d.act = s_q.far;
        end else if (top_ev || bot_ev) begin
            s_d.act = s_q.near;
        end

        if (!run)                  s_d.wave = 1'b0;
        else if (!tri_mode)        s_d.wave = (cnt < s_q.act);
        else if (cnt == s_q.act)   s_d.wave = up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wave = s_q.wave;

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !load && !top_ev && !bot_ev) |=> $stable(s_q.act));

endmodule

// File: rtl/pwm_dt.sv
`timescale 1ns/1ps
module pwm_dt #(
    parameter int unsigned DTW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           raw,
    input  logic [DTW-1:0] dt,
    output logic           out
);

    typedef struct packed {
        logic [DTW-1:0] hold;
        logic           out;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run || !raw) begin
            s_d.hold = '0;
            s_d.out  = 1'b0;
        end else begin
            if (s_q.hold != '1) s_d.hold = s_q.hold + DTW'(1);
            s_d.out = (s_q.hold >= dt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out = s_q.out;

    // R9
    fall_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !raw) |=> !s_q.out);

endmodule

// File: rtl/pwm_tri_timer.sv
`timescale 1ns/1ps
module pwm_tri_timer
    import pwm_tri_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          start,
    input  logic          stop,
    input  logic          clr,
    output logic          pin_a,
    output logic          pin_b,
    output logic          irq_ovf,
    output logic          irq_unf,
    output logic [CW-1:0] cnt_o,
    output logic          cnt_up_o
);

    localparam int unsigned DTW = CW - 8;
    localparam int unsigned NCH = 2;

    typedef struct packed {
        logic [CW-1:0]  period;
        ctrl_t          ctrl;
        logic [DTW-1:0] dt;
        logic           ovf;
        logic           unf;
    } st_t;

    st_t s_d, s_q;

    logic          run, up, top_ev, bot_ev, load;
    logic [CW-1:0] cnt;
    logic [NCH-1:0] wave, src, dto;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = top_ev;
        s_d.unf = bot_ev;
        if (wr_en && wr_addr == AD_LIMIT) s_d.period = wr_data;
        if (wr_en && wr_addr == AD_CTRL) begin
            s_d.ctrl = ctrl_t'(wr_data[7:0]);
            s_d.dt   = wr_data[CW-1:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load = start && !stop && !run;

    pwm_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .clr    (clr),
        .mode   (s_q.ctrl.mode),
        .period (s_q.period),
        .run    (run),
        .cnt    (cnt),
        .up     (up),
        .top_ev (top_ev),
        .bot_ev (bot_ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic near_hit, far_hit;
        assign near_hit = wr_en && (wr_addr == ADDR_W'(1 + 2 * g));
        assign far_hit  = wr_en && (wr_addr == ADDR_W'(2 + 2 * g));

        pwm_cmp #(.CW(CW)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_near  (near_hit),
            .wr_far   (far_hit),
            .wdata    (wr_data),
            .buf_en   (s_q.ctrl.buf_en),
            .xfer     (s_q.ctrl.xfer),
            .tri_mode (s_q.ctrl.mode[1]),
            .load     (load),
            .top_ev   (top_ev),
            .bot_ev   (bot_ev),
            .run      (run),
            .cnt      (cnt),
            .up       (up),
            .wave     (wave[g])
        );

        if (g == 0) begin : g_src_a
            assign src[g] = wave[0];
        end else begin : g_src_b
            assign src[g] = s_q.ctrl.comp ? ~wave[0] : wave[g];
        end

        pwm_dt #(.DTW(DTW)) u_dt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .raw   (src[g]),
            .dt    (s_q.dt),
            .out   (dto[g])
        );
    end

    assign pin_a    = run ? dto[0] : s_q.ctrl.idle_a;
    assign pin_b    = run ? dto[1] : s_q.ctrl.idle_b;
    assign irq_ovf  = s_q.ovf;
    assign irq_unf  = s_q.unf;
    assign cnt_o    = cnt;
    assign cnt_up_o = up;

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && s_q.ctrl.comp && $past(s_q.ctrl.comp)) |-> !(dto[0] && dto[1]));

endmodule

// File: tb/sim_pwm_tri_timer.sv
`timescale 1ns/1ps
module sim_pwm_tri_timer;

    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          start = 1'b0, stop = 1'b0, clr = 1'b0;
    logic          pin_a, pin_b, irq_ovf, irq_unf, cnt_up_o;
    logic [CW-1:0] cnt_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    pwm_tri_timer #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .stop(stop), .clr(clr), .pin_a(pin_a), .pin_b(pin_b),
        .irq_ovf(irq_ovf), .irq_unf(irq_unf), .cnt_o(cnt_o), .cnt_up_o(cnt_up_o)
    );

    // driver side: queue the expectation
    task automatic push_exp(input string tag, input int v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sb_q.push_back(e);
    endtask

    // monitor side: pop and compare an observed result
    task automatic sb_got(input int act);
        exp_t e;
        total++;
        if (sb_q.size() == 0) begin
            bad++;
            $display("FAIL scoreboard empty: got %0d expected none", act);
        end else begin
            e = sb_q.pop_front();
            if (act != e.val) begin
                bad++;
                $display("FAIL %s: got %0d expected %0d", e.tag, act, e.val);
            end
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        push_exp(tag, exp);
        sb_got(act);
    endtask

    function automatic logic [31:0] cw(input int mode, input int xf, input int be,
                                       input int cm, input int ia, input int ib, input int dt);
        return (32'(dt) << 8) | (32'(ib) << 7) | (32'(ia) << 6) | (32'(cm) << 5)
             | (32'(be) << 4) | (32'(xf) << 2) | 32'(mode);
    endfunction

    function automatic logic pinv(input int sel);
        return (sel != 0) ? pin_b : pin_a;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctl(input logic s, input logic p, input logic c);
        @(negedge clk);
        start = s; stop = p; clr = c;
        @(negedge clk);
        start = 1'b0; stop = 1'b0; clr = 1'b0;
    endtask

    task automatic cfg(input int p, input int a1, input int a2, input int b1, input int b2,
                       input logic [31:0] c);
        ctl(1'b0, 1'b1, 1'b1);
        wr(3'd0, 32'(p));
        wr(3'd1, 32'(a1));
        wr(3'd2, 32'(a2));
        wr(3'd3, 32'(b1));
        wr(3'd4, 32'(b2));
        wr(3'd5, c);
        ctl(1'b1, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
    endtask

    // width of the next complete high pulse, in clocks
    task automatic width(input int sel, output int w);
        int n;
        n = 0;
        while (pinv(sel) && n < 600) begin @(negedge clk); n++; end
        n = 0;
        while (!pinv(sel) && n < 600) begin @(negedge clk); n++; end
        w = 0;
        while (pinv(sel) && w < 600) begin w++; @(negedge clk); end
    endtask

    // clocks between two consecutive flag pulses
    task automatic gap_irq(input bit ovf, output int n);
        int k;
        k = 0;
        while (!(ovf ? irq_ovf : irq_unf) && k < 600) begin @(negedge clk); k++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!(ovf ? irq_ovf : irq_unf) && n < 600);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w, n, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 pin_a", int'(pin_a), 0);
        chk("R1 pin_b", int'(pin_b), 0);
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 irq", int'(irq_ovf | irq_unf), 0);

        // R2 rising sawtooth, R12 map
        cfg(15, 6, 0, 3, 0, cw(0, 0, 1, 0, 0, 0, 0));
        push_exp("R2 ovf interval", 16); gap_irq(1'b1, n); sb_got(n);
        push_exp("R2 width A", 6);       width(0, w);      sb_got(w);
        push_exp("R2 width B", 3);       width(1, w);      sb_got(w);

        // R3 falling sawtooth
        cfg(15, 4, 0, 0, 0, cw(1, 0, 1, 0, 0, 0, 0));
        push_exp("R3 unf interval", 16); gap_irq(1'b0, n); sb_got(n);
        push_exp("R3 width A", 4);       width(0, w);      sb_got(w);

        // R4 symmetric triangle
        cfg(20, 8, 8, 14, 14, cw(2, 3, 1, 0, 0, 0, 0));
        push_exp("R4 ovf interval", 40); gap_irq(1'b1, n); sb_got(n);
        push_exp("R4 unf interval", 40); gap_irq(1'b0, n); sb_got(n);
        push_exp("R4 width A", 24);      width(0, w);      sb_got(w);
        push_exp("R4 width B", 12);      width(1, w);      sb_got(w);

        // R5 asymmetric: near at trough, far at crest
        cfg(20, 5, 12, 0, 0, cw(2, 3, 1, 0, 0, 0, 0));
        push_exp("R5 both width", 23);   width(0, w);      sb_got(w);
        // R5 crest-only reload uses near buffer
        cfg(20, 5, 12, 0, 0, cw(3, 2, 1, 0, 0, 0, 0));
        push_exp("R5 crest width", 30);  width(0, w);      sb_got(w);

        // R6 write coinciding with the trough reload is deferred
        cfg(20, 8, 0, 0, 0, cw(2, 1, 1, 0, 0, 0, 0));
        n = 0;
        while (!(cnt_o == 0 && !cnt_up_o) && n < 200) begin @(negedge clk); n++; end
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd14;
        @(negedge clk);
        wr_en = 1'b0;
        push_exp("R6 old value", 24);    width(0, w);      sb_got(w);
        push_exp("R6 new value", 12);    width(0, w);      sb_got(w);

        // R7 unbuffered near register acts directly
        cfg(15, 6, 0, 0, 0, cw(0, 0, 0, 0, 0, 0, 0));
        push_exp("R7 width before", 6);  width(0, w);      sb_got(w);
        wr(3'd1, 32'd10);
        push_exp("R7 width after", 10);  width(0, w);      sb_got(w);

        // R8 complementary with dead time 3
        cfg(20, 8, 8, 0, 0, cw(2, 3, 1, 1, 0, 0, 3));
        push_exp("R8 width A", 21);      width(0, w);      sb_got(w);
        push_exp("R8 width B", 13);      width(1, w);      sb_got(w);
        n = 0;
        while (!pin_a && n < 200) begin @(negedge clk); n++; end
        while (pin_a && n < 400) begin @(negedge clk); n++; end
        w = 0;
        while (!pin_b && w < 100) begin w++; @(negedge clk); end
        chk("R8 gap A fall to B rise", w, 3);

        // R9 short pulse swallowed by dead time 5
        cfg(20, 18, 18, 0, 0, cw(2, 3, 1, 1, 0, 0, 5));
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pin_a) n++;
        end
        chk("R9 pin_a high samples", n, 0);
        push_exp("R9 width B", 31);      width(1, w);      sb_got(w);

        // R10 idle levels and held counter
        wr(3'd5, cw(2, 3, 1, 1, 1, 0, 5));
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 idle pin_a", int'(pin_a), 1);
        chk("R10 idle pin_b", int'(pin_b), 0);
        c0 = int'(cnt_o);
        repeat (5) @(negedge clk);
        chk("R10 counter held", int'(cnt_o), c0);
        wr(3'd5, cw(2, 3, 1, 1, 0, 1, 5));
        chk("R10 swapped pin_a", int'(pin_a), 0);
        chk("R10 swapped pin_b", int'(pin_b), 1);

        // R11 clear while stopped and while running
        ctl(1'b0, 1'b0, 1'b1);
        chk("R11 stopped clear", int'(cnt_o), 0);
        cfg(15, 6, 0, 0, 0, cw(0, 0, 1, 0, 0, 0, 0));
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R11 running clear", int'(cnt_o), 0);
        @(negedge clk);
        chk("R11 count resumes", int'(cnt_o), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule